// File: doc/BRIEF.md
# Prioritized Nesting Interrupt Controller

This block gathers interrupt requests from internal peripherals and from a small set of external pins, and presents them to a processor on two active-low lines: a normal request line (`nirq_o`) and a fast request line (`nfiq_o`). Every normal source has an enable bit and a 3-bit priority. A current-level register, backed by an eight-entry level stack, holds back any request whose priority is not strictly above the level being serviced. Higher-priority work can therefore interrupt lower-priority handlers, and equal-priority work must wait.

External pins pass through a two-flop synchronizer. Each pin can be set to level or edge detection, with a polarity of its own. Edge hits are held in sticky pending bits until software clears them. Any enabled external request also drives a wake-up output. A dedicated fast pin is detected on its falling edge and drives `nfiq_o` through a separate path that ignores priorities.

Software reaches the block through a plain register port. A write takes effect on the clock edge where `reg_we_i` is high. A read is combinational from `reg_addr_i`. The port has no handshake and no back-pressure.

Register map (word addresses):
- 0: source enable mask, bit i for source i.
- 1: external configuration. Bits [3:0] select edge mode per pin (1 = edge). Bits [7:4] set polarity per pin (1 = high level or rising edge, 0 = low level or falling edge). Reset value is 0xF0.
- 2: read gives the raw pending vector. A write of 1 clears the sticky bit of an external source.
- 3: read gives the vector: bit 8 = valid, bits [4:0] = source number. A write acknowledges the winner.
- 4: read gives the current level in bits [2:0] and the stack depth in bits [11:8]. A write ends service.
- 5: fast interrupt. Bit 0 = enable (R/W). Read bit 1 = pending. Write bit 1 = 1 clears pending.
- 32+i: priority of source i, bits [2:0].

Sources 0 to 18 are the internal inputs `irq_src_i`. Source 19+j is external pin j.

Top module: `prio_nest_intc`

## Requirements
- R1: After reset, `nirq_o` and `nfiq_o` are high, the enable mask reads 0, and register 4 reads 0 (level 0, depth 0).
- R2: A source whose enable bit (register 0) is 0 never pulls `nirq_o` low, whatever its request or priority.
- R3: Each source has a 3-bit priority at address 32+i. A source at priority 0 never requests.
- R4: The vector register (address 3) returns bit 8 = 1 and the number of the highest-priority eligible source in bits [4:0]. When two sources share the top level, the lower source number wins. With no eligible source, it reads 0.
- R5: `nirq_o` is low exactly while some enabled, pending source has a priority strictly greater than the current level. The output follows the inputs combinationally.
- R6: A write to address 3, made while a winner exists, pushes the current level and makes the winner's priority the new current level. A write to address 4 pops the stack and restores the previous level. That write is ignored when the stack is empty, as is an acknowledge made with no winner.
- R7: An external pin in level mode (config bit j = 0) requests while its synchronized value equals its polarity bit (config bit 4+j).
- R8: An external pin in edge mode sets a sticky pending bit on the selected edge only. The bit stays set after the pin returns, until a 1 is written to its position (19+j) at address 2.
- R9: A falling edge on `fiq_pin_n_i` sets a fast pending bit. `nfiq_o` is low while that bit and the fast enable (address 5, bit 0) are both 1. Writing bit 1 at address 5 clears the pending bit. Priorities and levels never affect this path.
- R10: `wake_o` is high while any enabled external source is requesting.
- R11: A change on an external pin in level mode reaches `nirq_o` at the second rising clock edge. An edge-mode hit reaches it at the third edge, and a fast-pin fall reaches `nfiq_o` at the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | 19 | Internal peripheral requests, active high, level |
| ext_pin_i | input | 4 | External interrupt pins, asynchronous |
| fiq_pin_n_i | input | 1 | Fast interrupt pin, falling-edge active, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |
| nirq_o | output | 1 | Normal interrupt request to processor, active low |
| nfiq_o | output | 1 | Fast interrupt request to processor, active low |
| wake_o | output | 1 | Wake-up request from external sources |

## Verification
A wrong entry in the level stack cannot be seen at once. It shows up only after the next end-of-service write: `nirq_o` then stays high over a source that should be eligible, or the vector points at a source that should be blocked. Register 4 exposes the level and depth directly in the same cycle. A stuck or lost sticky bit shows on `nirq_o` and `wake_o` one cycle after the edge would have registered, and it persists until cleared. A synchronizer with the wrong depth shifts the moment `nirq_o` falls by one cycle, so the bench samples on both sides of the expected edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADR_ENABLE = 0;
  localparam int ADR_EXTCFG = 1;
  localparam int ADR_PEND   = 2;
  localparam int ADR_VECTOR = 3;
  localparam int ADR_LEVEL  = 4;
  localparam int ADR_FAST   = 5;
  localparam int ADR_PRIO   = 32;
  localparam int VALID_BIT  = 8;
  localparam int DEPTH_LSB  = 8;
endpackage

// File: rtl/intc_ext_detect.sv
module intc_ext_detect #(
  parameter int N_EXT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] pin_i,
  input  logic [N_EXT-1:0] edge_sel_i,
  input  logic [N_EXT-1:0] pol_i,
  input  logic [N_EXT-1:0] clr_i,
  output logic [N_EXT-1:0] req_o
);
  for (genvar j = 0; j < N_EXT; j++) begin : g_pin
    logic s1_q, s2_q, s3_q, sticky_q;
    logic lvl_act, edge_hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0; s2_q <= 1'b0; s3_q <= 1'b0;
      end else begin
        s1_q <= pin_i[j]; s2_q <= s1_q; s3_q <= s2_q;
      end
    end

    always_comb begin
      lvl_act  = pol_i[j] ? s2_q : ~s2_q;
      edge_hit = edge_sel_i[j] & (pol_i[j] ? (s2_q & ~s3_q) : (~s2_q & s3_q));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sticky_q <= 1'b0;
      else if (edge_hit) sticky_q <= 1'b1;
      else if (clr_i[j]) sticky_q <= 1'b0;
    end

    assign req_o[j] = edge_sel_i[j] ? sticky_q : lvl_act;

    // R8: a captured edge persists until software clears it
    a_r8_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
      sticky_q && !clr_i[j] |=> sticky_q);
  end
endmodule

// File: rtl/intc_prio_arb.sv
module intc_prio_arb #(
  parameter int N_SRC = 23,
  parameter int LVL_W = 3,
  localparam int ID_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]       req_i,
  input  logic [N_SRC*LVL_W-1:0] lvl_flat_i,
  input  logic [LVL_W-1:0]       cur_lvl_i,
  output logic                   valid_o,
  output logic [ID_W-1:0]        id_o,
  output logic [LVL_W-1:0]       lvl_o
);
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    lvl_o   = cur_lvl_i;
    for (int i = 0; i < N_SRC; i++) begin
      if (req_i[i] && (lvl_flat_i[i*LVL_W +: LVL_W] > lvl_o)) begin
        valid_o = 1'b1;
        id_o    = ID_W'(i);
        lvl_o   = lvl_flat_i[i*LVL_W +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/intc_lvl_stack.sv
module intc_lvl_stack #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 3,
  localparam int SP_W  = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [LVL_W-1:0] push_lvl_i,
  input  logic             pop_i,
  output logic [LVL_W-1:0] cur_o,
  output logic [SP_W-1:0]  depth_o
);
  logic [LVL_W-1:0] mem_q [DEPTH];
  logic [LVL_W-1:0] cur_q;
  logic [SP_W-1:0]  sp_q;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  assign wr_idx = sp_q[IDX_W-1:0];
  assign rd_idx = wr_idx - IDX_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      sp_q  <= '0;
    end else if (push_i && sp_q < SP_W'(DEPTH)) begin
      cur_q <= push_lvl_i;
      sp_q  <= sp_q + SP_W'(1);
    end else if (pop_i && sp_q != '0) begin
      cur_q <= mem_q[rd_idx];
      sp_q  <= sp_q - SP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push_i && sp_q < SP_W'(DEPTH)) mem_q[wr_idx] <= cur_q;
  end

  assign cur_o   = cur_q;
  assign depth_o = sp_q;

  // R6: depth never exceeds the stack size
  a_r6_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SP_W'(DEPTH));
  // R6: end-of-service on an empty stack leaves level 0
  a_r6_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && !push_i && sp_q == '0 |=> sp_q == '0 && cur_q == '0);
endmodule

// File: rtl/prio_nest_intc.sv
module prio_nest_intc
  import intc_pkg::*;
#(
  parameter int N_INT   = 19,
  parameter int N_EXT   = 4,
  parameter int LVL_W   = 3,
  parameter int STACK_D = 8,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_INT-1:0]  irq_src_i,
  input  logic [N_EXT-1:0]  ext_pin_i,
  input  logic              fiq_pin_n_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              nirq_o,
  output logic              nfiq_o,
  output logic              wake_o
);
  localparam int N_SRC = N_INT + N_EXT;
  localparam int ID_W  = $clog2(N_SRC);
  localparam int SP_W  = $clog2(STACK_D + 1);

  logic [N_SRC-1:0]       en_q;
  logic [N_EXT-1:0]       edge_q, pol_q;
  logic [LVL_W-1:0]       prio_q [N_SRC];
  logic [N_SRC*LVL_W-1:0] prio_flat;
  logic [N_EXT-1:0]       ext_req, ext_clr;
  logic [N_SRC-1:0]       src_req;
  logic                   win_valid;
  logic [ID_W-1:0]        win_id;
  logic [LVL_W-1:0]       win_lvl, cur_lvl;
  logic [SP_W-1:0]        depth;
  logic                   ack, eos;
  logic                   fs1_q, fs2_q, fs3_q, fiq_pend_q, fiq_en_q;

  function automatic logic hit(input int a);
    return reg_we_i && (reg_addr_i == ADDR_W'(a));
  endfunction

  assign ack     = hit(ADR_VECTOR);
  assign eos     = hit(ADR_LEVEL);
  assign ext_clr = hit(ADR_PEND) ? reg_wdata_i[N_INT +: N_EXT] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      edge_q <= '0;
      pol_q  <= '1;
    end else begin
      if (hit(ADR_ENABLE)) en_q <= reg_wdata_i[N_SRC-1:0];
      if (hit(ADR_EXTCFG)) begin
        edge_q <= reg_wdata_i[N_EXT-1:0];
        pol_q  <= reg_wdata_i[2*N_EXT-1:N_EXT];
      end
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                prio_q[i] <= '0;
      else if (hit(ADR_PRIO + i)) prio_q[i] <= reg_wdata_i[LVL_W-1:0];
    end
    assign prio_flat[i*LVL_W +: LVL_W] = prio_q[i];
  end

  intc_ext_detect #(.N_EXT(N_EXT)) u_ext (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_pin_i), .edge_sel_i(edge_q),
    .pol_i(pol_q), .clr_i(ext_clr), .req_o(ext_req)
  );

  assign src_req = {ext_req, irq_src_i};

  intc_prio_arb #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_arb (
    .req_i(src_req & en_q), .lvl_flat_i(prio_flat), .cur_lvl_i(cur_lvl),
    .valid_o(win_valid), .id_o(win_id), .lvl_o(win_lvl)
  );

  intc_lvl_stack #(.DEPTH(STACK_D), .LVL_W(LVL_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push_i(ack && win_valid), .push_lvl_i(win_lvl),
    .pop_i(eos), .cur_o(cur_lvl), .depth_o(depth)
  );

  // fast path: synchronizer idles high so reset gives no false fall
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs1_q <= 1'b1; fs2_q <= 1'b1; fs3_q <= 1'b1;
      fiq_pend_q <= 1'b0; fiq_en_q <= 1'b0;
    end else begin
      fs1_q <= fiq_pin_n_i; fs2_q <= fs1_q; fs3_q <= fs2_q;
      if (!fs2_q && fs3_q)                          fiq_pend_q <= 1'b1;
      else if (hit(ADR_FAST) && reg_wdata_i[1])     fiq_pend_q <= 1'b0;
      if (hit(ADR_FAST))                            fiq_en_q   <= reg_wdata_i[0];
    end
  end

  assign nirq_o = ~win_valid;
  assign nfiq_o = ~(fiq_pend_q & fiq_en_q);
  assign wake_o = |(ext_req & en_q[N_INT +: N_EXT]);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_W'(ADR_ENABLE): reg_rdata_o[N_SRC-1:0] = en_q;
      ADDR_W'(ADR_EXTCFG): reg_rdata_o[2*N_EXT-1:0] = {pol_q, edge_q};
      ADDR_W'(ADR_PEND):   reg_rdata_o[N_SRC-1:0] = src_req;
      ADDR_W'(ADR_VECTOR): begin
        reg_rdata_o[ID_W-1:0]  = win_id;
        reg_rdata_o[VALID_BIT] = win_valid;
      end
      ADDR_W'(ADR_LEVEL): begin
        reg_rdata_o[LVL_W-1:0]           = cur_lvl;
        reg_rdata_o[DEPTH_LSB +: SP_W]   = depth;
      end
      ADDR_W'(ADR_FAST):   reg_rdata_o[1:0] = {fiq_pend_q, fiq_en_q};
      default: begin
        for (int i = 0; i < N_SRC; i++)
          if (reg_addr_i == ADDR_W'(ADR_PRIO + i)) reg_rdata_o[LVL_W-1:0] = prio_q[i];
      end
    endcase
  end

  // R5: a request reaches the processor only above the level in service
  a_r5_above_level: assert property (@(posedge clk) disable iff (!rst_n)
    !nirq_o |-> prio_q[win_id] > cur_lvl);
  // R3: a priority-0 source never wins
  a_r3_no_zero_winner: assert property (@(posedge clk) disable iff (!rst_n)
    !nirq_o |-> prio_q[win_id] != '0);
  // R2: the winner is always an enabled source
  a_r2_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    !nirq_o |-> en_q[win_id]);
  // R6: an accepted acknowledge strictly raises the current level
  a_r6_nest_rises: assert property (@(posedge clk) disable iff (!rst_n)
    ack && win_valid && depth < SP_W'(STACK_D) |=> cur_lvl > $past(cur_lvl));
  // R9: the fast line needs its enable
  a_r9_fast_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    !nfiq_o |-> fiq_en_q);
endmodule

// File: tb/prio_nest_intc_tb.sv
module prio_nest_intc_tb_top;
  localparam int CLK_P = 10;
  localparam int NI = 19, NE = 4;
  localparam int A_EN = 0, A_CFG = 1, A_PND = 2, A_VEC = 3, A_LVL = 4, A_FST = 5, A_PRI = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NI-1:0] irq_src = '0;
  logic [NE-1:0] ext_pin = '0;
  logic fiq_n = 1'b1, we = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic nirq, nfiq, wake;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  prio_nest_intc dut_i (
    .clk(clk), .rst_n(rst_n), .irq_src_i(irq_src), .ext_pin_i(ext_pin),
    .fiq_pin_n_i(fiq_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .nirq_o(nirq), .nfiq_o(nfiq), .wake_o(wake)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    we = 1'b1; addr = 6'(a); wdata = 32'(d);
    @(negedge clk);
    we = 1'b0;
    #1;
  endtask

  task automatic rd(input int a, output int d);
    addr = 6'(a);
    #1;
    d = int'(rdata);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int v;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 nirq", nirq, 1);
    chk("R1 nfiq", nfiq, 1);
    rd(A_EN, v);  chk("R1 enable", v, 0);
    rd(A_LVL, v); chk("R1 level", v, 0);

    // R2 R3 R4 R5: every internal source at every priority
    for (int i = 0; i < NI; i++) begin
      for (int p = 0; p < 8; p++) begin
        wr(A_PRI + i, p);
        wr(A_EN, 1 << i);
        irq_src = NI'(1) << i;
        #1;
        chk("R5 R3 single source nirq", nirq, (p == 0) ? 1 : 0);
        rd(A_VEC, v);
        chk("R4 vector single", v, (p == 0) ? 0 : (256 | i));
        wr(A_EN, 0);
        chk("R2 masked source", nirq, 1);
        irq_src = '0;
      end
      wr(A_PRI + i, 0);
    end

    // R4: pairwise ordering and ties between sources 3 and 7
    irq_src = NI'((1 << 3) | (1 << 7));
    wr(A_EN, (1 << 3) | (1 << 7));
    for (int pa = 1; pa < 8; pa++) begin
      for (int pb = 1; pb < 8; pb++) begin
        wr(A_PRI + 3, pa);
        wr(A_PRI + 7, pb);
        rd(A_VEC, v);
        chk("R4 pair order", v, 256 | ((pb > pa) ? 7 : 3));
      end
    end
    irq_src = '0;
    wr(A_EN, 0);
    wr(A_PRI + 3, 0); wr(A_PRI + 7, 0);

    // R6: acknowledge with no winner is ignored
    wr(A_VEC, 0);
    rd(A_LVL, v); chk("R6 ack no winner", v, 0);

    // R6 R5: nesting
    wr(A_PRI + 2, 3); wr(A_PRI + 5, 6); wr(A_PRI + 9, 3); wr(A_PRI + 10, 6);
    wr(A_EN, (1 << 2) | (1 << 5) | (1 << 9) | (1 << 10));
    irq_src = NI'((1 << 2) | (1 << 5) | (1 << 9));
    #1;
    rd(A_VEC, v); chk("R4 nest first winner", v, 256 | 5);
    wr(A_VEC, 0);
    rd(A_LVL, v); chk("R6 push level", v, 6 | (1 << 8));
    chk("R5 lower blocked", nirq, 1);
    irq_src[10] = 1'b1;
    #1;
    chk("R5 equal level blocked", nirq, 1);
    wr(A_PRI + 10, 7);
    chk("R5 higher passes", nirq, 0);
    rd(A_VEC, v); chk("R4 nested winner", v, 256 | 10);
    wr(A_VEC, 0);
    rd(A_LVL, v); chk("R6 second push", v, 7 | (2 << 8));
    chk("R5 top level blocks all", nirq, 1);
    wr(A_LVL, 0);
    rd(A_LVL, v); chk("R6 pop restores", v, 6 | (1 << 8));
    wr(A_LVL, 0);
    rd(A_LVL, v); chk("R6 pop to base", v, 0);
    rd(A_VEC, v); chk("R4 after pops", v, 256 | 10);
    wr(A_LVL, 0);
    rd(A_LVL, v); chk("R6 pop on empty", v, 0);
    irq_src = '0;
    wr(A_EN, 0);
    for (int i = 0; i < 11; i++) wr(A_PRI + i, 0);

    // R7 R8 R10 R11: each external pin
    for (int j = 0; j < NE; j++) begin
      wr(A_PRI + NI + j, 4);
      wr(A_EN, 1 << (NI + j));
      wr(A_CFG, 32'hF0);
      ext_pin[j] = 1'b1;
      tick(1); #1;
      chk("R11 level not yet", nirq, 1);
      tick(1); #1;
      chk("R7 R11 level high active", nirq, 0);
      chk("R10 wake", wake, 1);
      rd(A_VEC, v); chk("R4 ext vector", v, 256 | (NI + j));
      ext_pin[j] = 1'b0;
      tick(2); #1;
      chk("R7 level released", nirq, 1);
      chk("R10 wake released", wake, 0);
      wr(A_CFG, 32'h00);
      tick(2); #1;
      chk("R7 low active level", nirq, 0);
      ext_pin[j] = 1'b1;
      tick(2); #1;
      chk("R7 low active released", nirq, 1);
      // rising edge mode
      wr(A_CFG, 32'hFF);
      ext_pin[j] = 1'b0;
      tick(3);
      wr(A_PND, -1);
      chk("R8 idle edge", nirq, 1);
      ext_pin[j] = 1'b1;
      tick(2); #1;
      chk("R11 edge not yet", nirq, 1);
      tick(1); #1;
      chk("R8 R11 rising edge", nirq, 0);
      ext_pin[j] = 1'b0;
      tick(3); #1;
      chk("R8 sticky holds", nirq, 0);
      chk("R10 wake sticky", wake, 1);
      rd(A_PND, v); chk("R8 pending bit", (v >> (NI + j)) & 1, 1);
      wr(A_PND, 1 << (NI + j));
      chk("R8 cleared", nirq, 1);
      // falling edge mode
      wr(A_CFG, 32'h0F);
      ext_pin[j] = 1'b1;
      tick(3); #1;
      chk("R8 rise ignored in falling mode", nirq, 1);
      ext_pin[j] = 1'b0;
      tick(3); #1;
      chk("R8 falling edge", nirq, 0);
      wr(A_PND, 1 << (NI + j));
      chk("R8 falling cleared", nirq, 1);
      wr(A_EN, 0);
      wr(A_PRI + NI + j, 0);
    end
    wr(A_CFG, 32'hF0);

    // R9: fast path
    wr(A_FST, 1);
    fiq_n = 1'b0;
    tick(2); #1;
    chk("R11 fast not yet", nfiq, 1);
    tick(1); #1;
    chk("R9 R11 fast falls", nfiq, 0);
    chk("R9 nirq independent", nirq, 1);
    fiq_n = 1'b1;
    tick(3); #1;
    chk("R9 fast held", nfiq, 0);
    wr(A_FST, 3);
    chk("R9 fast cleared", nfiq, 1);
    wr(A_FST, 0);
    fiq_n = 1'b0;
    tick(3); #1;
    chk("R9 masked fast", nfiq, 1);
    rd(A_FST, v); chk("R9 pending visible", v, 2);
    wr(A_FST, 1);
    chk("R9 unmask shows", nfiq, 0);
    wr(A_FST, 3);
    chk("R9 clear again", nfiq, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule